// File: doc/BRIEF.md
# Uncut Net Fitness Evaluator

This block scores one two-way split of a small netlist. The solution arrives as a vector with one bit per cell, and the bit value picks that cell's side. The block reads a netlist memory in which each word is the cell bitmask of one net. It counts every net whose cells all fall on one side and reports that count as the fitness. A larger fitness means a better split.

A single start pulse, given while the block is idle, captures the solution vector. The block then reads nets 0 to M-1, one address per clock, through a synchronous read port whose latency is a parameter. When the last net has been judged, done pulses for one cycle and the new fitness appears. The fitness holds until the next job completes.

States and transitions: `ST_IDLE` goes to `ST_ISSUE` on an accepted start. `ST_ISSUE` issues one read per cycle and goes to `ST_DRAIN` after issuing the last address. `ST_DRAIN` waits for the last returning word and then goes to `ST_FINISH`. `ST_FINISH` asserts done for one cycle and returns to `ST_IDLE`.

Top module: `ufe_top`

## Requirements
- R1: Bit i of `part_vec` gives the side of cell i: 0 places it on side 0 and 1 places it on side 1. A net with mask m is uncut when (m AND vec) is all zeros or equals m.
- R2: The fitness equals the number of uncut nets among the M memory words. A word that is all zeros is an empty net and is never counted. With cells 1, 3 and 5 on side 1 and nets {0,1,4}, {0,2}, {1,2,3}, {2,3}, {1,5}, the fitness is 2.
- R3: Once a start is accepted, `rom_rd_en` is high for exactly M consecutive cycles. `rom_addr` runs 0, 1, ..., M-1 during those cycles, beginning in the cycle after the accepting edge.
- R4: Each returning word is taken RD_LAT cycles after the memory captures its address. RD_LAT is a parameter of at least 1.
- R5: `done` is high for exactly one cycle. That cycle follows the (M+RD_LAT)-th rising edge after the edge that accepted start.
- R6: `fitness` takes its new value in the cycle in which `done` is high. It changes at no other time.
- R7: `busy` is high from the accepting edge through the `done` cycle. A start seen while `busy` is high is ignored.
- R8: The solution vector is captured at the accepting edge. Later changes to `part_vec` have no effect on the result of that job.
- R9: After reset, `busy`, `done`, `rom_rd_en` and `fitness` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a job when the block is idle |
| part_vec | input | N | Side of each cell, one bit per cell |
| rom_rd_en | output | 1 | Netlist read request |
| rom_addr | output | $clog2(M) | Net index being read |
| rom_data | input | N | Cell mask of the net, RD_LAT cycles after the address is captured |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle completion pulse |
| fitness | output | $clog2(M+1) | Count of uncut nets from the last completed job |

## Verification
Counting from the accepting edge, the first read is due one cycle later and the reads continue through cycle M. `done` and the new fitness are due after edge M+RD_LAT, and `busy` drops one edge after that. The bench models the read port with the same RD_LAT delay. A behavioural reference advances a cycle counter from the accepting edge and predicts `busy`, `done`, `rom_rd_en`, `rom_addr` and `fitness` for every cycle. All of these are compared on the falling edge, away from the edge at which they change. The expected fitness is recomputed in the bench from the memory contents and the captured vector.

// File: rtl/ufe_pkg.sv
package ufe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_FINISH = 2'd3
    } ufe_state_e;
endpackage

// File: rtl/ufe_addr_seq.sv
// Net index counter: cleared on job start, stepped once per issued read.
module ufe_addr_seq #(
    parameter int M  = 64,
    localparam int AW = (M > 1) ? $clog2(M) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          at_last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (clear) begin
            addr <= '0;
        end else if (step) begin
            addr <= addr + AW'(1);
        end
    end

    assign at_last = (addr == AW'(M - 1));
endmodule

// File: rtl/ufe_lat_pipe.sv
// Delay line that tags returning memory words with a valid and a last-net flag.
module ufe_lat_pipe #(
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_vld,
    input  logic in_last,
    output logic out_vld,
    output logic out_last
);
    logic [RD_LAT-1:0] vld_q;
    logic [RD_LAT-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q[0]  <= 1'b0;
            last_q[0] <= 1'b0;
        end else begin
            vld_q[0]  <= in_vld;
            last_q[0] <= in_vld & in_last;
        end
    end

    for (genvar g = 1; g < RD_LAT; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[g]  <= 1'b0;
                last_q[g] <= 1'b0;
            end else begin
                vld_q[g]  <= vld_q[g-1];
                last_q[g] <= last_q[g-1];
            end
        end
    end

    assign out_vld  = vld_q[RD_LAT-1];
    assign out_last = last_q[RD_LAT-1];
endmodule

// File: rtl/ufe_net_judge.sv
// Decides whether one net is non-empty and lies wholly on one side.
module ufe_net_judge #(
    parameter int N = 32
) (
    input  logic [N-1:0] mask,
    input  logic [N-1:0] vec,
    output logic         uncut
);
    logic [N-1:0] on_one;

    always_comb begin
        on_one = mask & vec;
        uncut  = (|mask) && ((on_one == '0) || (on_one == mask));
    end
endmodule

// File: rtl/ufe_top.sv
module ufe_top
    import ufe_pkg::*;
#(
    parameter int N      = 32,
    parameter int M      = 64,
    parameter int RD_LAT = 2,
    localparam int AW    = (M > 1) ? $clog2(M) : 1,
    localparam int FW    = $clog2(M + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [N-1:0]  part_vec,
    output logic          rom_rd_en,
    output logic [AW-1:0] rom_addr,
    input  logic [N-1:0]  rom_data,
    output logic          busy,
    output logic          done,
    output logic [FW-1:0] fitness
);
    ufe_state_e state_q, state_d;

    logic [N-1:0]  vec_q;
    logic [FW-1:0] acc_q;
    logic [FW-1:0] fit_q;
    logic          accept;
    logic          issue;
    logic          at_last;
    logic          ret_vld;
    logic          ret_last;
    logic          net_uncut;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)              state_d = ST_ISSUE;
            ST_ISSUE:  if (at_last)            state_d = ST_DRAIN;
            ST_DRAIN:  if (ret_vld && ret_last) state_d = ST_FINISH;
            ST_FINISH:                         state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        accept    = 1'b0;
        issue     = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   begin busy = 1'b0; accept = start; end
            ST_ISSUE:  issue = 1'b1;
            ST_DRAIN:  ;
            ST_FINISH: done = 1'b1;
            default:   busy = 1'b0;
        endcase
        rom_rd_en = issue;
        fitness   = fit_q;
    end

    ufe_addr_seq #(.M(M)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .step    (issue),
        .addr    (rom_addr),
        .at_last (at_last)
    );

    ufe_lat_pipe #(.RD_LAT(RD_LAT)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (issue),
        .in_last  (at_last),
        .out_vld  (ret_vld),
        .out_last (ret_last)
    );

    ufe_net_judge #(.N(N)) u_judge (
        .mask  (rom_data),
        .vec   (vec_q),
        .uncut (net_uncut)
    );

    // datapath: captured vector, running count, published result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
            acc_q <= '0;
            fit_q <= '0;
        end else begin
            if (accept) begin
                vec_q <= part_vec;
                acc_q <= '0;
            end else if (ret_vld) begin
                acc_q <= acc_q + FW'(net_uncut);
                if (ret_last) fit_q <= acc_q + FW'(net_uncut);
            end
        end
    end
endmodule

// File: rtl/ufe_checker.sv
module ufe_checker #(
    parameter int AW = 6,
    parameter int FW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          rom_rd_en,
    input logic [AW-1:0] rom_addr,
    input logic          busy,
    input logic          done,
    input logic [FW-1:0] fitness
);
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd_en && $past(rom_rd_en)) |-> (rom_addr == $past(rom_addr) + AW'(1)));

    a_r3_addr_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_rd_en) |-> (rom_addr == '0));

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_busy_covers_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r7_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

    a_r6_fit_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(fitness));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rom_rd_en && !done));
endmodule

bind ufe_top ufe_checker #(.AW(AW), .FW(FW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rom_rd_en (rom_rd_en),
    .rom_addr  (rom_addr),
    .busy      (busy),
    .done      (done),
    .fitness   (fitness)
);

// File: tb/sim_ufe_top.sv
`timescale 1ns/1ps
module sim_ufe_top;
    localparam int N   = 32;
    localparam int M   = 64;
    localparam int LAT = 2;
    localparam int AW  = $clog2(M);
    localparam int FW  = $clog2(M + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [N-1:0]  part_vec = '0;
    logic          rom_rd_en;
    logic [AW-1:0] rom_addr;
    logic [N-1:0]  rom_data;
    logic          busy;
    logic          done;
    logic [FW-1:0] fitness;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    ufe_top #(.N(N), .M(M), .RD_LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .part_vec(part_vec),
        .rom_rd_en(rom_rd_en), .rom_addr(rom_addr), .rom_data(rom_data),
        .busy(busy), .done(done), .fitness(fitness)
    );

    // netlist memory with a LAT-cycle synchronous read
    logic [N-1:0]  mem [M];
    logic [AW-1:0] stg [LAT];
    always @(posedge clk) begin
        stg[0] <= rom_addr;
        for (int j = 1; j < LAT; j++) stg[j] <= stg[j-1];
    end
    assign rom_data = mem[stg[LAT-1]];

    function automatic int score(input logic [N-1:0] v);
        int s = 0;
        for (int k = 0; k < M; k++) begin
            if (mem[k] != '0 && (((mem[k] & v) == '0) || ((mem[k] & v) == mem[k]))) s++;
        end
        return s;
    endfunction

    // behavioural reference, cycle by cycle
    bit ref_busy, ref_done;
    int ref_cnt, ref_fit, ref_pend;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_busy <= 0; ref_done <= 0; ref_cnt <= 0; ref_fit <= 0; ref_pend <= 0;
        end else if (!ref_busy) begin
            if (start) begin
                ref_busy <= 1; ref_cnt <= 0; ref_pend <= score(part_vec);
            end
        end else begin
            ref_cnt <= ref_cnt + 1;
            if (ref_cnt + 1 == M + LAT) begin ref_done <= 1; ref_fit <= ref_pend; end
            if (ref_cnt + 1 == M + LAT + 1) begin ref_done <= 0; ref_busy <= 0; end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        cycles++;
        check("R7 busy", int'(busy), int'(ref_busy));
        check("R5 done", int'(done), int'(ref_done));
        check("R6 fitness", int'(fitness), ref_fit);
        check("R3 rd_en", int'(rom_rd_en), int'(ref_busy && ref_cnt < M));
        if (ref_busy && ref_cnt < M) check("R3 R4 addr", int'(rom_addr), ref_cnt);
        if (cycles > 150000) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic run_job(input logic [N-1:0] v, output int result);
        @(negedge clk);
        while (busy) @(negedge clk);
        part_vec = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        result = int'(fitness);
    endtask

    logic [31:0] lfsr = 32'hACE1_1234;
    function automatic logic [31:0] nxt(input logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    initial begin
        int r;
        int fit_before;
        for (int k = 0; k < M; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        check("R9 reset busy", int'(busy), 0);
        check("R9 reset fitness", int'(fitness), 0);
        check("R9 reset rd_en", int'(rom_rd_en), 0);
        rst_n = 1'b1;

        // R2 worked example: cells 1,3,5 on side 1
        mem[0] = 32'b010011; mem[1] = 32'b000101; mem[2] = 32'b001110;
        mem[3] = 32'b001100; mem[4] = 32'b100010;
        run_job(32'b101010, r);
        check("R2 example", r, 2);
        // R1 swapped sides give the same count
        run_job(32'b010101, r);
        check("R1 swapped sides", r, 2);
        // R1 all on one side: every non-empty net uncut, empty ones skipped
        run_job('0, r);
        check("R1 R2 all side0", r, 5);
        run_job('1, r);
        check("R1 R2 all side1", r, 5);

        // random netlist including a full mask and empties
        for (int k = 0; k < M; k++) begin
            lfsr = nxt(lfsr); lfsr = nxt(lfsr);
            mem[k] = (k % 7 == 3) ? '0 : (lfsr & nxt(lfsr));
        end
        mem[M-1] = '1;
        for (int t = 0; t < 6; t++) begin
            lfsr = nxt(nxt(lfsr));
            run_job(lfsr, r);
            check("R2 random", r, score(lfsr));
        end

        // R7/R8: start and vector change during a job are ignored
        fit_before = score(32'h0F0F_0F0F);
        @(negedge clk);
        part_vec = 32'h0F0F_0F0F; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        part_vec = 32'hFFFF_0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check("R7 R8 busy start ignored", int'(fitness), fit_before);
        @(negedge clk);
        check("R7 idle after done", int'(busy), 0);

        // R6 result holds while idle
        repeat (20) @(negedge clk);
        check("R6 hold", int'(fitness), fit_before);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule